// File: doc/BRIEF.md
# Blinking Seven-Segment Floor Display

This block drives one seven-segment digit that shows which floor a lift cabin is on. A floor index comes in, and the block puts out the matching segment pattern on a 7-bit vector. Each segment is lit by a logic 1. Segment a sits in the most significant bit and segment g in the least significant bit. There is only one digit, so the block has no digit-select or anode output.

When the lift controller reports an arrival with a one-cycle pulse, the digit flashes five times and then shows the floor steadily again. Each flash has a dark phase followed by a lit phase. Both phases last `PHASE_CYCLES` clocks. With the default of 25,000,000 cycles at 50 MHz, the ten phases fill five seconds. A bench can use a short value instead.

A new arrival during a flash sequence starts the count of five again from the beginning. During the lit phases the digit shows whatever floor index is present at that time. The `OUT_REG` option adds an output register, so the segment pins change only on clock edges.

Top module: `floor_seg_blinker`

## Requirements
- R1: With no blink in progress, floors 0 to 4 give these codes (bit 6 = a ... bit 0 = g, 1 = lit): 0 → 7'h7E, 1 → 7'h30, 2 → 7'h6D, 3 → 7'h79, 4 → 7'h33.
- R2: A floor index of `NUM_FLOORS` (default 5) or more gives all segments off (7'h00).
- R3: An arrival pulse sampled at a clock edge makes the display dark for the next `PHASE_CYCLES` cycles. It then lights for `PHASE_CYCLES` cycles, and dark and lit phases keep alternating. With `OUT_REG`=1, every output change appears one cycle later.
- R4: Exactly five dark phases follow one arrival. After the fifth lit phase, which ends 10·`PHASE_CYCLES` cycles after the arrival edge, the display stays steady.
- R5: An arrival sampled while a sequence is running restarts it from the first dark phase with a full count of five. An arrival held high restarts the sequence on every edge where it is high.
- R6: During lit phases and in steady display, the digit shows the floor index present at that time. A floor change shows up within the same output latency.
- R7: While reset is asserted (active-low, asynchronous), no blink is in progress, and with `OUT_REG`=1 the output is 7'h00. After reset is released, the digit shows the floor steadily, with no blink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| floor_i | input | FLOOR_W (3) | Current floor index |
| arrive_i | input | 1 | Arrival pulse that starts or restarts the five blinks |
| seg_o | output | 7 | Segments a..g, bit 6 = a, active high |

## Verification
The bench goes after four kinds of failure:
- The phase boundaries at exactly `PHASE_CYCLES` and 10·`PHASE_CYCLES`. An off-by-one counter would stretch or clip a phase, or would add or drop a sixth blink. The bench counts dark cycles over a whole sequence.
- A second arrival in the middle of a sequence. A design that ignored it, or that only reset the phase timer, would end too early.
- Floor changes during a blink. A design that latched the floor at arrival would show a stale digit.
- Out-of-range indices and a reset in mid-sequence. These catch a decoder that aliases index 5 to 7 onto real digits, and a blink that survives reset.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;

   localparam int SEG_BITS = 7;

   typedef logic [SEG_BITS-1:0] seg_pattern_t;

   // Decimal glyphs, bit 6 = segment a ... bit 0 = segment g, 1 = lit.
   function automatic seg_pattern_t digit_glyph(input logic [3:0] d);
      seg_pattern_t g;
      case (d)
         4'd0:    g = 7'b111_1110;
         4'd1:    g = 7'b011_0000;
         4'd2:    g = 7'b110_1101;
         4'd3:    g = 7'b111_1001;
         4'd4:    g = 7'b011_0011;
         4'd5:    g = 7'b101_1011;
         4'd6:    g = 7'b101_1111;
         4'd7:    g = 7'b111_0000;
         4'd8:    g = 7'b111_1111;
         4'd9:    g = 7'b111_1011;
         default: g = '0;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/seg_glyph_rom.sv
module seg_glyph_rom
   import seg_disp_pkg::*;
#(
   parameter int FLOOR_W    = 3,
   parameter int NUM_FLOORS = 5
) (
   input  logic [FLOOR_W-1:0] floor_i,
   output seg_pattern_t       glyph_o
);

   localparam int IDX_MAX = NUM_FLOORS - 1;

   always_comb begin
      if (32'(floor_i) <= IDX_MAX) glyph_o = digit_glyph(4'(floor_i));
      else                         glyph_o = '0;
   end

endmodule

// File: rtl/blink_sequencer.sv
module blink_sequencer #(
   parameter int PHASE_CYCLES = 25_000_000,
   parameter int BLINK_COUNT  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arrive_i,
   output logic blank_o,
   output logic busy_o
);

   localparam int TICK_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
   localparam int CNT_W  = $clog2(BLINK_COUNT + 1);
   localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(PHASE_CYCLES - 1);
   localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(BLINK_COUNT - 1);

   logic              busy_q, blank_q;
   logic [TICK_W-1:0] tick_q;
   logic [CNT_W-1:0]  done_q;
   logic              phase_end;

   assign phase_end = (tick_q == TICK_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         blank_q <= 1'b0;
         tick_q  <= '0;
         done_q  <= '0;
      end else if (arrive_i) begin
         busy_q  <= 1'b1;
         blank_q <= 1'b1;
         tick_q  <= '0;
         done_q  <= '0;
      end else if (busy_q) begin
         if (phase_end) begin
            tick_q <= '0;
            if (!blank_q && done_q == CNT_LAST) begin
               busy_q <= 1'b0;
            end else begin
               blank_q <= ~blank_q;
               if (!blank_q) done_q <= done_q + 1'b1;
            end
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   assign blank_o = blank_q;
   assign busy_o  = busy_q;

   p_tick_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (32'(tick_q) < PHASE_CYCLES));

   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arrive_i |=> (busy_q && blank_q && tick_q == '0 && done_q == '0));

   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (32'(done_q) < BLINK_COUNT));

   p_finish_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (!$past(blank_q) && $past(done_q) == CNT_LAST));

   p_idle_lit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !blank_q);

endmodule

// File: rtl/floor_seg_blinker.sv
module floor_seg_blinker
   import seg_disp_pkg::*;
#(
   parameter int FLOOR_W      = 3,
   parameter int NUM_FLOORS   = 5,
   parameter int PHASE_CYCLES = 25_000_000,
   parameter int BLINK_COUNT  = 5,
   parameter bit OUT_REG      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FLOOR_W-1:0] floor_i,
   input  logic               arrive_i,
   output logic [6:0]         seg_o
);

   if (NUM_FLOORS < 1 || NUM_FLOORS > 10)
      $error("NUM_FLOORS must lie in 1..10");
   if (NUM_FLOORS > (1 << FLOOR_W))
      $error("FLOOR_W too narrow for NUM_FLOORS");
   if (PHASE_CYCLES < 1)
      $error("PHASE_CYCLES must be at least 1");
   if (BLINK_COUNT < 1)
      $error("BLINK_COUNT must be at least 1");

   seg_pattern_t glyph, seg_next;
   logic         blank, busy;

   seg_glyph_rom #(.FLOOR_W(FLOOR_W), .NUM_FLOORS(NUM_FLOORS)) rom_i (
      .floor_i (floor_i),
      .glyph_o (glyph)
   );

   blink_sequencer #(.PHASE_CYCLES(PHASE_CYCLES), .BLINK_COUNT(BLINK_COUNT)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .arrive_i (arrive_i),
      .blank_o  (blank),
      .busy_o   (busy)
   );

   assign seg_next = blank ? '0 : glyph;

   if (OUT_REG) begin : g_out_reg
      seg_pattern_t seg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) seg_q <= '0;
         else        seg_q <= seg_next;
      end
      assign seg_o = seg_q;
   end else begin : g_out_comb
      assign seg_o = seg_next;
   end

   p_blank_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(floor_i) >= NUM_FLOORS) |-> (glyph == '0));

   p_lit_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && 32'(floor_i) < NUM_FLOORS) |-> (seg_next != '0));

   p_dark_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> busy);

endmodule

// File: tb/floor_seg_blinker_tb_top.sv
`timescale 1ns/1ps
module floor_seg_blinker_tb_top;

   localparam int FW     = 3;
   localparam int NFL    = 5;
   localparam int PH     = 4;
   localparam int NBL    = 5;
   localparam bit OREG   = 1'b1;
   localparam int WINDOW = 2 * NBL * PH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [FW-1:0] floor_i = '0;
   logic          arrive_i = 1'b0;
   logic [6:0]    seg_o;

   int     n_checks = 0;
   int     n_fail   = 0;
   string  cur_req  = "R7";
   bit     wd_hit   = 1'b0;
   bit     counting = 1'b0;
   int     dark_cnt = 0;

   int         since = -1;
   logic [6:0] exp_reg = '0;

   always #10 clk = ~clk;

   floor_seg_blinker #(
      .FLOOR_W(FW), .NUM_FLOORS(NFL), .PHASE_CYCLES(PH),
      .BLINK_COUNT(NBL), .OUT_REG(OREG)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .floor_i(floor_i),
      .arrive_i(arrive_i), .seg_o(seg_o)
   );

   function automatic logic [6:0] ref_glyph(input int f);
      case (f)
         0: return 7'h7E;
         1: return 7'h30;
         2: return 7'h6D;
         3: return 7'h79;
         4: return 7'h33;
         default: return 7'h00;
      endcase
   endfunction

   function automatic logic [6:0] ref_seg(input int s, input int f);
      if (s >= 0 && s < WINDOW && ((s / PH) % 2 == 0)) return 7'h00;
      return ref_glyph(f);
   endfunction

   // behavioural reference: cycles since the last arrival edge
   always @(posedge clk) begin
      if (!rst_n) begin
         since   = -1;
         exp_reg = 7'h00;
      end else begin
         exp_reg = ref_seg(since, int'(floor_i));
         if (arrive_i)                         since = 0;
         else if (since >= 0 && since < WINDOW) since = since + 1;
      end
   end

   task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: seg_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !wd_hit) begin
         check(cur_req, seg_o, OREG ? exp_reg : ref_seg(since, int'(floor_i)));
         if (counting && seg_o == 7'h00) dark_cnt++;
      end
   end

   task automatic drive(input int f, input bit arr);
      @(posedge clk);
      #2;
      floor_i  = FW'(f);
      arrive_i = arr;
   endtask

   task automatic hold(input int f, input int n);
      for (int i = 0; i < n; i++) drive(f, 1'b0);
   endtask

   initial begin
      #4_000_000;
      wd_hit = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R7: reset state
      repeat (3) @(negedge clk);
      check("R7", seg_o, 7'h00);
      @(posedge clk); #2; rst_n = 1'b1; floor_i = 3'd1;
      cur_req = "R7";
      hold(1, 3);

      // R1: steady digits
      cur_req = "R1";
      for (int f = 0; f < NFL; f++) hold(f, 3);

      // R2: out-of-range indices blank
      cur_req = "R2";
      for (int f = NFL; f < 8; f++) hold(f, 3);
      hold(0, 2);

      // R3/R4: one full sequence, dark cycles counted
      cur_req = "R3";
      drive(2, 1'b1);
      drive(2, 1'b0);
      counting = 1'b1; dark_cnt = 0;
      hold(2, WINDOW + 6);
      counting = 1'b0;
      n_checks++;
      if (dark_cnt != NBL * PH) begin
         n_fail++;
         $display("FAIL R4: dark cycles=%0d expected %0d", dark_cnt, NBL * PH);
      end
      cur_req = "R4";
      hold(2, 4);

      // R6: floor changes during the blink
      cur_req = "R6";
      drive(3, 1'b1);
      hold(3, PH + 1);
      hold(1, PH);
      hold(7, PH);
      hold(4, PH * 4);
      hold(0, WINDOW);

      // R5: restart in mid-sequence, then held arrival
      cur_req = "R5";
      drive(4, 1'b1);
      hold(4, 13);
      drive(4, 1'b1);
      counting = 1'b1; dark_cnt = 0;
      hold(4, WINDOW + 4);
      counting = 1'b0;
      n_checks++;
      if (dark_cnt != NBL * PH) begin
         n_fail++;
         $display("FAIL R5: dark cycles after restart=%0d expected %0d", dark_cnt, NBL * PH);
      end
      drive(1, 1'b1); drive(1, 1'b1); drive(1, 1'b1);
      hold(1, WINDOW + 4);

      // R7: reset in mid-blink clears the sequence
      cur_req = "R7";
      drive(2, 1'b1);
      hold(2, 3);
      @(posedge clk); #2; rst_n = 1'b0;
      @(negedge clk);
      check("R7", seg_o, 7'h00);
      @(posedge clk); #2; rst_n = 1'b1;
      hold(2, WINDOW);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule